// File: doc/BRIEF.md
# Absolute Position Frame Receiver

This block is the controller side of a one-way serial link to an absolute position sensor. On a request it drives a clock line towards the sensor. It reads the sensor's data line once per clock period and waits through the acknowledge and busy interval until the start bit arrives. It then discards the control bit that follows and shifts in a 40-bit position word, two fault flags and a 6-bit check value.

A CRC with generator x^6 + x + 1 is run over the position and flag bits as they arrive. It is compared with the received check value, which the sensor sends complemented. On a match the new position and flags are published with a one-cycle strobe. On a mismatch the previous values are kept and an error strobe asks the host to issue a new request. When no start bit arrives within a set number of clock periods, a timeout strobe reports a missing or stuck sensor. After every frame or timeout the clock line rests high for a programmable recovery time before the next request is accepted.

Top module: `posframe_rx`

## Requirements
- R1: While idle, `enc_clk_o` is high. A request accepted at a clock edge drives it low at that edge. It then alternates, staying HALF_PERIOD system cycles in each level, with the low level first.
- R2: The data line is read once per sensor clock period, at the edge that ends the (SAMPLE_DELAY+1)-th system cycle after `enc_clk_o` rises.
- R3: Reads of 1 before the first 0 are the acknowledge wait. Reads of 0 are busy. The first read of 1 after at least one 0 is the start bit. The read that follows is a control bit with no effect on any output.
- R4: After the control bit, 48 reads arrive in this order: position bit 39 down to bit 0, then the error flag, then the warning flag, then the 6 check bits MSB first.
- R5: The check is a CRC of width 6 with polynomial x^6 + x + 1 (taps 0x03). The register starts at zero and takes the 42 position and flag bits MSB first. The frame is good when the bitwise complement of the 6 received check bits equals the CRC.
- R6: The edge that takes the last check bit raises `frame_valid` for exactly one cycle. In the same cycle `crc_ok` shows the result, and for a good frame `position`, `n_err` and `n_warn` show the new values.
- R7: For a bad frame, `crc_err` pulses together with `frame_valid`, `crc_ok` is 0, and `position`, `n_err`, `n_warn` keep their previous values.
- R8: `n_err` and `n_warn` are active low (1 means no fault) and are published as received.
- R9: After the last check bit, or after a timeout, `enc_clk_o` stays high and `busy` stays 1 for REST_CYCLES system cycles. After that the block is idle and can accept a request.
- R10: If ACK_TIMEOUT reads pass in the acknowledge and busy interval without a start bit, `timeout` pulses for one cycle at the edge of the last of those reads. No frame strobe follows, and the recovery of R9 begins.
- R11: A request while `busy` is 1 has no effect.
- R12: After reset: `enc_clk_o`=1, `busy`=0, all strobes 0, `crc_ok`=0, `position`=0, `n_err`=1, `n_warn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request a position frame (taken while idle) |
| enc_data_i | input | 1 | Serial data from the sensor |
| enc_clk_o | output | 1 | Clock line to the sensor, idle high |
| busy | output | 1 | A frame, timeout or recovery is in progress |
| frame_valid | output | 1 | One-cycle strobe: frame complete |
| crc_ok | output | 1 | Check result of the last completed frame |
| crc_err | output | 1 | One-cycle strobe: check mismatch, request again |
| timeout | output | 1 | One-cycle strobe: no start bit in time |
| position | output | POS_W | Last good position word |
| n_err | output | 1 | Last good error flag, active low |
| n_warn | output | 1 | Last good warning flag, active low |

## Verification
A wrong phase counter or stale sampling point shows up first on `enc_clk_o` or on the read data. The bench models the clock line and the end-of-frame cycle from the request, so a clock that is off by one period is seen within that period. A fault in the frame sequencer or the CRC path shows only when the frame ends, about fifty sensor clock periods after the request. It appears as a strobe in the wrong cycle, a wrong check verdict, or a position or flag that changed when it should have been held. Frames with different acknowledge and busy lengths, a corrupted check value, a zero control bit and stray requests are used so that each of these faults changes the outputs of at least one frame.

// File: rtl/posrx_pkg.sv
package posrx_pkg;

   // frame sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ACK,
      PH_BUSY,
      PH_CTRL,
      PH_DATA,
      PH_REST
   } phase_e;

endpackage

// File: rtl/posrx_clkgen.sv
// Sensor clock generator with a delayed sampling strobe inside each high phase.
module posrx_clkgen #(
   parameter int HALF_PERIOD  = 8,
   parameter int SAMPLE_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic halt,
   output logic sclk,
   output logic smp
);
   localparam int CW = (HALF_PERIOD < 2) ? 1 : $clog2(HALF_PERIOD);

   logic          active;
   logic [CW-1:0] cnt;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (launch) begin
         active <= 1'b1;
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (halt) begin
         active <= 1'b0;
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (active) begin
         if (cnt == CW'(HALF_PERIOD - 1)) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sclk = sclk_q;
   assign smp  = active && sclk_q && (cnt == CW'(SAMPLE_DELAY));

   a_r1_idle_clock_high : assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> sclk_q);

   a_r1_level_held : assert property (@(posedge clk) disable iff (!rst_n)
      (active && !launch && !halt && cnt != CW'(HALF_PERIOD - 1)) |=> $stable(sclk_q));

endmodule

// File: rtl/posrx_crc.sv
// Serial CRC, MSB first, taps given by POLY (without the top term).
module posrx_crc #(
   parameter int               W    = 6,
   parameter logic [W-1:0]     POLY = 6'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic [W-1:0] crc_q;
   logic [W-1:0] nxt;
   logic         fb;

   assign fb = crc_q[W-1] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = POLY[i] & fb;
      end else begin : g_upper
         assign nxt[i] = crc_q[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '0;
      else if (clr) crc_q <= '0;
      else if (en)  crc_q <= nxt;
   end

   assign crc = crc_q;

   a_r5_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_q == '0));

   a_r5_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(crc_q));

endmodule

// File: rtl/posframe_rx.sv
module posframe_rx
   import posrx_pkg::*;
#(
   parameter int                 POS_W        = 40,
   parameter int                 CRC_W        = 6,
   parameter logic [CRC_W-1:0]   CRC_POLY     = 6'h03,
   parameter int                 HALF_PERIOD  = 8,
   parameter int                 SAMPLE_DELAY = 2,
   parameter int                 ACK_TIMEOUT  = 64,
   parameter int                 REST_CYCLES  = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             enc_data_i,
   output logic             enc_clk_o,
   output logic             busy,
   output logic             frame_valid,
   output logic             crc_ok,
   output logic             crc_err,
   output logic             timeout,
   output logic [POS_W-1:0] position,
   output logic             n_err,
   output logic             n_warn
);
   localparam int DATA_BITS = POS_W + 2;
   localparam int TOT_BITS  = DATA_BITS + CRC_W;
   localparam int WCW       = $clog2(ACK_TIMEOUT + 1);
   localparam int BCW       = $clog2(TOT_BITS + 1);
   localparam int RCW       = $clog2(REST_CYCLES + 1);

   // elaboration-time parameter checks
   if (HALF_PERIOD < 2) begin : g_bad_half
      $error("HALF_PERIOD must be at least 2");
   end
   if (SAMPLE_DELAY < 0 || SAMPLE_DELAY >= HALF_PERIOD) begin : g_bad_delay
      $error("SAMPLE_DELAY must lie inside one half period");
   end
   if (CRC_W < 2 || POS_W < 1) begin : g_bad_width
      $error("CRC_W must be >= 2 and POS_W >= 1");
   end
   if (ACK_TIMEOUT < 1 || REST_CYCLES < 1) begin : g_bad_time
      $error("ACK_TIMEOUT and REST_CYCLES must be positive");
   end

   phase_e               phase;
   logic [WCW-1:0]       wait_cnt;
   logic [BCW-1:0]       bit_cnt;
   logic [RCW-1:0]       rest_cnt;
   logic [DATA_BITS-1:0] data_sr;
   logic [CRC_W-1:0]     rx_crc;
   logic [CRC_W-1:0]     crc_val;
   logic [CRC_W-1:0]     rx_full;

   logic smp, sclk, launch, halt;
   logic in_wait, is_start, wait_last, to_hit;
   logic data_last, frame_end, crc_en, match;

   logic             valid_q, ok_q, err_q, to_q;
   logic [POS_W-1:0] pos_q;
   logic             nerr_q, nwarn_q;

   assign launch    = (phase == PH_IDLE) && req_i;
   assign in_wait   = (phase == PH_ACK) || (phase == PH_BUSY);
   assign is_start  = (phase == PH_BUSY) && enc_data_i;
   assign wait_last = (wait_cnt == WCW'(ACK_TIMEOUT - 1));
   assign to_hit    = smp && in_wait && !is_start && wait_last;
   assign data_last = (bit_cnt == BCW'(TOT_BITS - 1));
   assign frame_end = smp && (phase == PH_DATA) && data_last;
   assign halt      = to_hit || frame_end;
   assign crc_en    = smp && (phase == PH_DATA) && (bit_cnt < BCW'(DATA_BITS));
   assign rx_full   = {rx_crc[CRC_W-2:0], enc_data_i};
   assign match     = ((~rx_full) == crc_val);

   posrx_clkgen #(
      .HALF_PERIOD (HALF_PERIOD),
      .SAMPLE_DELAY(SAMPLE_DELAY)
   ) i_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(launch),
      .halt  (halt),
      .sclk  (sclk),
      .smp   (smp)
   );

   posrx_crc #(
      .W   (CRC_W),
      .POLY(CRC_POLY)
   ) i_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (launch),
      .en   (crc_en),
      .din  (enc_data_i),
      .crc  (crc_val)
   );

   // frame sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         wait_cnt <= '0;
         bit_cnt  <= '0;
         rest_cnt <= '0;
         data_sr  <= '0;
         rx_crc   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (req_i) begin
                  phase    <= PH_ACK;
                  wait_cnt <= '0;
               end
            end
            PH_ACK, PH_BUSY: begin
               if (smp) begin
                  if (is_start) begin
                     phase <= PH_CTRL;
                  end else if (wait_last) begin
                     phase    <= PH_REST;
                     rest_cnt <= '0;
                  end else begin
                     wait_cnt <= wait_cnt + 1'b1;
                     if (!enc_data_i) phase <= PH_BUSY;
                  end
               end
            end
            PH_CTRL: begin
               // control bit is consumed and not used
               if (smp) begin
                  phase   <= PH_DATA;
                  bit_cnt <= '0;
               end
            end
            PH_DATA: begin
               if (smp) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt < BCW'(DATA_BITS)) data_sr <= {data_sr[DATA_BITS-2:0], enc_data_i};
                  else                           rx_crc  <= rx_full;
                  if (data_last) begin
                     phase    <= PH_REST;
                     rest_cnt <= '0;
                  end
               end
            end
            PH_REST: begin
               if (rest_cnt == RCW'(REST_CYCLES - 1)) phase <= PH_IDLE;
               else                                   rest_cnt <= rest_cnt + 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // result registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         to_q    <= 1'b0;
         pos_q   <= '0;
         nerr_q  <= 1'b1;
         nwarn_q <= 1'b1;
      end else begin
         valid_q <= frame_end;
         err_q   <= frame_end && !match;
         to_q    <= to_hit;
         if (frame_end) begin
            ok_q <= match;
            if (match) begin
               pos_q   <= data_sr[DATA_BITS-1:2];
               nerr_q  <= data_sr[1];
               nwarn_q <= data_sr[0];
            end
         end
      end
   end

   assign enc_clk_o   = sclk;
   assign busy        = (phase != PH_IDLE);
   assign frame_valid = valid_q;
   assign crc_ok      = ok_q;
   assign crc_err     = err_q;
   assign timeout     = to_q;
   assign position    = pos_q;
   assign n_err       = nerr_q;
   assign n_warn      = nwarn_q;

   a_r6_valid_single : assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   a_r7_err_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> (frame_valid && !crc_ok));

   a_r7_hold_on_err : assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> ($stable(position) && $stable(n_err) && $stable(n_warn)));

   a_r9_clock_high_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> enc_clk_o);

   a_r10_timeout_rests : assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (busy && enc_clk_o && !frame_valid));

   a_r11_req_busy_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_i && phase != PH_REST) |=> busy);

   a_r4_bit_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (bit_cnt < BCW'(TOT_BITS)));

endmodule

// File: tb/test_posframe_rx.sv
`timescale 1ns/1ps
module test_posframe_rx;
   localparam int H   = 4;
   localparam int L   = 3;
   localparam int TO  = 8;
   localparam int TM  = 20;
   localparam int SD  = 2;   // sensor output delay after a clock rise
   localparam int NB  = 48;  // bits after the control bit

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        slo = 1'b1;
   logic        ma, busy, fv, ok, err, to;
   logic [39:0] pos;
   logic        ne, nw;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic [39:0] e_pos = '0;
   logic        e_ne = 1'b1, e_nw = 1'b1, e_ok = 1'b0;

   logic sq [0:127];
   int   sq_n;

   always #2 clk = ~clk;

   posframe_rx #(
      .POS_W(40), .CRC_W(6), .CRC_POLY(6'h03),
      .HALF_PERIOD(H), .SAMPLE_DELAY(L),
      .ACK_TIMEOUT(TO), .REST_CYCLES(TM)
   ) i_posframe_rx (
      .clk(clk), .rst_n(rst_n), .req_i(req), .enc_data_i(slo),
      .enc_clk_o(ma), .busy(busy), .frame_valid(fv), .crc_ok(ok),
      .crc_err(err), .timeout(to), .position(pos), .n_err(ne), .n_warn(nw)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp = n_cmp + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] ref_crc(input logic [41:0] m);
      logic [5:0] c;
      logic       fb;
      c = '0;
      for (int i = 41; i >= 0; i--) begin
         fb = c[5] ^ m[i];
         c  = {c[4:0], 1'b0};
         if (fb) c = c ^ 6'h03;
      end
      return c;
   endfunction

   // one request and everything it causes, compared on every cycle
   task automatic run_frame(input int a, input int b, input logic cds, input logic [39:0] p,
                            input logic fe, input logic fw, input logic corrupt,
                            input logic absent, input int req_at);
      logic [5:0] c;
      int   n_smp, kf, rise, cd, idx;
      logic is_to, good, mp, e_ma;
      string ptag;
      c = ref_crc({p, fe, fw});
      sq_n = 0;
      if (!absent) begin
         for (int i = 0; i < a; i++) begin sq[sq_n] = 1'b1; sq_n++; end
         for (int i = 0; i < b; i++) begin sq[sq_n] = 1'b0; sq_n++; end
         sq[sq_n] = 1'b1; sq_n++;                // start
         sq[sq_n] = cds;  sq_n++;                // control bit
         for (int i = 39; i >= 0; i--) begin sq[sq_n] = p[i]; sq_n++; end
         sq[sq_n] = fe; sq_n++;
         sq[sq_n] = fw; sq_n++;
         for (int i = 5; i >= 0; i--) begin sq[sq_n] = ~c[i]; sq_n++; end
         if (corrupt) sq[sq_n-1] = ~sq[sq_n-1];
      end
      is_to = absent || (a + b >= TO);
      n_smp = is_to ? TO : (a + b + 2 + NB);
      kf    = (n_smp - 1) * 2 * H + H + L + 1;
      good  = !corrupt;
      ptag  = corrupt ? "R7" : "R2/R4";
      if (req_at == -2) req_at = kf + 2;        // request during recovery
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      rise = 0; cd = 0; mp = 1'b0;
      for (int k = 0; k < kf + TM + 3; k++) begin
         req = (k == req_at);                     // R11: ignored while busy
         // sensor model
         if (ma && !mp) begin
            rise++;
            cd = SD;
         end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               idx = rise - 1;
               slo = (idx < sq_n) ? sq[idx] : 1'b1;
            end
         end
         mp = ma;
         // expected outputs
         e_ma = (k >= kf) ? 1'b1 : (((k % (2 * H)) < H) ? 1'b0 : 1'b1);
         if (k == kf && !is_to) begin
            e_ok = good;
            if (good) begin e_pos = p; e_ne = fe; e_nw = fw; end
         end
         chk("R1/R11", "enc_clk", 64'(ma), 64'(e_ma));
         chk("R9", "busy", 64'(busy), 64'(k < kf + TM));
         chk("R3/R6", "frame_valid", 64'(fv), 64'(k == kf && !is_to));
         chk("R7", "crc_err", 64'(err), 64'(k == kf && !is_to && !good));
         chk("R10", "timeout", 64'(to), 64'(k == kf && is_to));
         chk("R5", "crc_ok", 64'(ok), 64'(e_ok));
         chk(ptag, "position", 64'(pos), 64'(e_pos));
         chk("R8", "n_err", 64'(ne), 64'(e_ne));
         chk("R8", "n_warn", 64'(nw), 64'(e_nw));
         @(negedge clk);
      end
      req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12", "enc_clk", 64'(ma), 64'd1);
      chk("R12", "busy", 64'(busy), 64'd0);
      chk("R12", "strobes", 64'({fv, err, to}), 64'd0);
      chk("R12", "crc_ok", 64'(ok), 64'd0);
      chk("R12", "position", 64'(pos), 64'd0);
      chk("R12", "flags", 64'({ne, nw}), 64'b11);
      // good frame, no faults
      run_frame(1, 2, 1'b1, 40'hA5_3C0F_96E1, 1'b1, 1'b1, 1'b0, 1'b0, -1);
      // no acknowledge wait, error flag active, stray request mid-frame (R11)
      run_frame(0, 4, 1'b1, 40'h00_0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 30);
      // corrupted check value: R7 hold and re-request strobe
      run_frame(2, 1, 1'b1, 40'hFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, -1);
      // control bit 0 has no effect (R3), request during recovery (R11)
      run_frame(1, 1, 1'b0, 40'h00_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, -2);
      // sensor absent: R10 timeout
      run_frame(0, 0, 1'b1, 40'h12_3456_789A, 1'b1, 1'b1, 1'b0, 1'b1, -1);
      // sensor stuck busy: R10 timeout
      run_frame(1, 20, 1'b1, 40'h12_3456_789A, 1'b1, 1'b1, 1'b0, 1'b0, -1);
      // busy ends on the last allowed read
      run_frame(3, 4, 1'b1, 40'h12_3456_789A, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      // MSB-only word, warning flag active
      run_frame(3, 1, 1'b1, 40'h80_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, -1);
      // another corrupted frame after a good one
      run_frame(0, 1, 1'b1, 40'h5A_5A5A_5A5A, 1'b0, 1'b1, 1'b1, 1'b0, -1);
      summary();
      $finish;
   end

endmodule